// File: doc/BRIEF.md
# Debug Access Mode Controller

This block sits between a processor core's two-bit debug status code and a debug message port. It follows whether the core is halted in debug mode and keeps the debug-access configuration that a debug tool applies while system reset is held. From these it decides which trace streams may run and raises single-cycle message requests: identification, debug-entry status and program-trace resynchronization. It also decides whether incoming debug data messages are taken or dropped.

Configuration has three bits. Access selects development access for the debug port. Debug-enable turns debug mode on. Halt-at-reset asks the core to stop as it leaves reset. When debug-enable is 0 the block runs in running-access mode: the halt-at-reset bit has no effect and the core is never halted by configuration. The core reports that it has entered debug mode with status code 0b11. This code means the same thing whether the halt came from configuration, from a downloaded breakpoint or from an exception.

Message requests queue in a small pending set. While either reset is asserted they are held back. Once both resets are low they are issued one per cycle in priority order.

Top module: `dbg_access_ctrl`

## Requirements
- R1: While `port_rst` is high at a clock edge, the configuration is cleared, `halt_req` goes to 0 after that edge, and `msg_req` stays 0 for the whole time `port_rst` is high.
- R2: After a port reset, one identification request (`msg_type` = 2'b01) is issued. It appears combinationally in the first cycle in which both `port_rst` and `sys_rst` are low, and it lasts exactly one cycle. No request is issued while `sys_rst` is high.
- R3: The three configuration inputs are captured only at edges where `sys_rst` is high. Changes made while `sys_rst` is low have no effect on `rw_gate`, `msg_accept` or `halt_req`.
- R4: When an edge with `sys_rst` high captures debug-enable = 1 and halt-at-reset = 1, `halt_req` goes to 1 after that edge. It falls after the first edge, with `sys_rst` low, at which the registered status is 0b11. If debug-enable is 0, `halt_req` is 0 whatever halt-at-reset is.
- R5: When `core_status` is first sampled as 0b11 and debug-enable is configured, one status request (`msg_type` = 2'b10) is pending after the next edge. It is therefore visible one cycle after the edge that registered 0b11. Codes 0b00, 0b01 and 0b10 raise no status request, and nothing is raised when debug-enable is 0.
- R6: Holding `core_status` at 0b11 for any number of cycles yields no further status request.
- R7: `ptrace_gate` equals `ptrace_en` while the registered status is not 0b11, and is 0 while it is 0b11. The status is registered on the edge after `core_status` is sampled.
- R8: `dtrace_gate` follows `dtrace_en`, and `rw_gate` follows the configured access bit, both regardless of debug mode.
- R9: When the registered status leaves 0b11 while `ptrace_en` is 1, one resynchronization request (`msg_type` = 2'b11) becomes visible one edge after the exit is registered. If `ptrace_en` is 0 at that point, no request is raised.
- R10: `msg_accept` is 1 only when `msg_in_valid` is 1 and the access bit is configured. Otherwise the incoming message is dropped.
- R11: When several requests are pending, they are issued one per cycle in the order identification, status, resynchronization. None is lost.
- R12: Entry into debug mode from any earlier code (0b00, 0b01, 0b10) produces the same status request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| port_rst | input | 1 | Synchronous active-high debug-port reset |
| sys_rst | input | 1 | System reset; configuration is captured while high |
| cfg_access | input | 1 | Development-access configuration bit |
| cfg_dbg_en | input | 1 | Debug-enable configuration bit |
| cfg_halt_rst | input | 1 | Halt-at-reset configuration bit |
| core_status | input | STAT_W | Core debug status code; 0b11 means halted in debug mode |
| ptrace_en | input | 1 | Program trace enable from the tool |
| dtrace_en | input | 1 | Data trace enable from the tool |
| msg_in_valid | input | 1 | Incoming debug data message strobe |
| halt_req | output | 1 | Request for the core to halt |
| ptrace_gate | output | 1 | Program trace permitted |
| dtrace_gate | output | 1 | Data trace permitted |
| rw_gate | output | 1 | Read/write development access permitted |
| msg_accept | output | 1 | Incoming data message accepted |
| msg_req | output | 1 | Single-cycle message request |
| msg_type | output | 2 | Request type: 01 identification, 10 status, 11 resynchronization |

## Verification
The configuration is swept over all eight combinations of its three bits while system reset is held, with the incoming-message strobe toggled at each setting. This separates halt requests, acceptance and access gating per bit. The status code is walked through all four values, each with program trace on and off, which separates the halt-state gate from the trace enable. Entry into debug mode is tried from every earlier code, and exit is tried with trace off, to tell real edges from steady levels. Finally, entry and exit are queued behind the identification request during system reset, which shows the issue order and that no request is lost.

// File: rtl/dbg_access_pkg.sv
package dbg_access_pkg;

    localparam int NUM_KINDS = 3;
    localparam int KIND_ID   = 0;
    localparam int KIND_STAT = 1;
    localparam int KIND_SYNC = 2;

    typedef enum logic [1:0] {
        MK_NONE = 2'd0,
        MK_ID   = 2'd1,
        MK_STAT = 2'd2,
        MK_SYNC = 2'd3
    } msg_kind_e;

    typedef struct packed {
        logic access;
        logic dbg_en;
        logic halt_rst;
    } dbg_cfg_t;

    // Pending-slot index to wire type code: slot order is also the issue priority.
    function automatic msg_kind_e kind_code(input int idx);
        return msg_kind_e'(idx + 1);
    endfunction

endpackage

// File: rtl/dbg_cfg_latch.sv
module dbg_cfg_latch
    import dbg_access_pkg::*;
(
    input  logic     clk,
    input  logic     port_rst,
    input  logic     sys_rst,
    input  dbg_cfg_t cfg_in,
    input  logic     core_halted,
    output dbg_cfg_t cfg_q,
    output logic     halt_q
);

    always_ff @(posedge clk) begin
        if (port_rst) begin
            cfg_q  <= '0;
            halt_q <= 1'b0;
        end else if (sys_rst) begin
            cfg_q  <= cfg_in;
            halt_q <= cfg_in.dbg_en & cfg_in.halt_rst;
        end else if (core_halted) begin
            halt_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_mode_tracker.sv
module dbg_mode_tracker #(
    parameter int              STAT_W   = 2,
    parameter logic [STAT_W-1:0] DBG_CODE = '1
) (
    input  logic              clk,
    input  logic              port_rst,
    input  logic [STAT_W-1:0] core_status,
    output logic              in_dbg,
    output logic              enter_p,
    output logic              exit_p
);

    logic [STAT_W-1:0] stat_q;
    logic              dbg_q;

    always_ff @(posedge clk) begin
        if (port_rst) begin
            stat_q <= '0;
            dbg_q  <= 1'b0;
        end else begin
            stat_q <= core_status;
            dbg_q  <= in_dbg;
        end
    end

    assign in_dbg  = (stat_q == DBG_CODE);
    assign enter_p = in_dbg & ~dbg_q;
    assign exit_p  = ~in_dbg & dbg_q;

endmodule

// File: rtl/dbg_msg_arbiter.sv
module dbg_msg_arbiter
    import dbg_access_pkg::*;
#(
    parameter int N = NUM_KINDS
) (
    input  logic         clk,
    input  logic         port_rst,
    input  logic         hold,
    input  logic [N-1:0] ev,
    output logic         msg_req,
    output logic [1:0]   msg_type
);

    logic [N-1:0] pend;
    logic [N-1:0] grant;

    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam logic RST_V = (i == KIND_ID);
        logic q;
        always_ff @(posedge clk) begin
            if (port_rst) q <= RST_V;
            else          q <= (q & ~grant[i]) | ev[i];
        end
        assign pend[i] = q;
    end

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (!hold && pend[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        msg_type = MK_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) msg_type = kind_code(i);
        end
    end

    assign msg_req = |grant;

endmodule

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
    import dbg_access_pkg::*;
#(
    parameter int                STAT_W   = 2,
    parameter logic [STAT_W-1:0] DBG_CODE = '1
) (
    input  logic              clk,
    input  logic              port_rst,
    input  logic              sys_rst,
    input  logic              cfg_access,
    input  logic              cfg_dbg_en,
    input  logic              cfg_halt_rst,
    input  logic [STAT_W-1:0] core_status,
    input  logic              ptrace_en,
    input  logic              dtrace_en,
    input  logic              msg_in_valid,
    output logic              halt_req,
    output logic              ptrace_gate,
    output logic              dtrace_gate,
    output logic              rw_gate,
    output logic              msg_accept,
    output logic              msg_req,
    output logic [1:0]        msg_type
);

    dbg_cfg_t           cfg_in;
    dbg_cfg_t           cfg_q;
    logic               in_dbg;
    logic               enter_p;
    logic               exit_p;
    logic [NUM_KINDS-1:0] ev;

    assign cfg_in = '{access: cfg_access, dbg_en: cfg_dbg_en, halt_rst: cfg_halt_rst};

    dbg_cfg_latch u_cfg (
        .clk         (clk),
        .port_rst    (port_rst),
        .sys_rst     (sys_rst),
        .cfg_in      (cfg_in),
        .core_halted (in_dbg),
        .cfg_q       (cfg_q),
        .halt_q      (halt_req)
    );

    dbg_mode_tracker #(
        .STAT_W   (STAT_W),
        .DBG_CODE (DBG_CODE)
    ) u_mode (
        .clk         (clk),
        .port_rst    (port_rst),
        .core_status (core_status),
        .in_dbg      (in_dbg),
        .enter_p     (enter_p),
        .exit_p      (exit_p)
    );

    // Identification events come only from the reset value of its slot.
    assign ev[KIND_ID]   = 1'b0;
    assign ev[KIND_STAT] = enter_p & cfg_q.dbg_en;
    assign ev[KIND_SYNC] = exit_p & ptrace_en;

    dbg_msg_arbiter #(.N(NUM_KINDS)) u_arb (
        .clk      (clk),
        .port_rst (port_rst),
        .hold     (port_rst | sys_rst),
        .ev       (ev),
        .msg_req  (msg_req),
        .msg_type (msg_type)
    );

    assign ptrace_gate = ptrace_en & ~in_dbg;
    assign dtrace_gate = dtrace_en;
    assign rw_gate     = cfg_q.access;
    assign msg_accept  = msg_in_valid & cfg_q.access;

endmodule

// File: rtl/dbg_access_chk.sv
module dbg_access_chk #(
    parameter int                STAT_W   = 2,
    parameter logic [STAT_W-1:0] DBG_CODE = '1
) (
    input logic              clk,
    input logic              port_rst,
    input logic              sys_rst,
    input logic              cfg_access,
    input logic              cfg_dbg_en,
    input logic              cfg_halt_rst,
    input logic [STAT_W-1:0] core_status,
    input logic              ptrace_en,
    input logic              dtrace_en,
    input logic              msg_in_valid,
    input logic              halt_req,
    input logic              ptrace_gate,
    input logic              dtrace_gate,
    input logic              rw_gate,
    input logic              msg_accept,
    input logic              msg_req,
    input logic [1:0]        msg_type
);

    // R1
    quiet_in_port_reset_chk: assert property (@(posedge clk)
        port_rst |-> !msg_req);

    // R2
    held_in_sys_reset_chk: assert property (@(posedge clk)
        sys_rst |-> !msg_req);

    // R3
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (port_rst)
        (!sys_rst && !port_rst) |=> $stable(rw_gate));

    // R4
    halt_needs_enable_chk: assert property (@(posedge clk) disable iff (port_rst)
        (sys_rst && !cfg_dbg_en) |=> !halt_req);

    // R6
    no_repeat_status_chk: assert property (@(posedge clk) disable iff (port_rst)
        (msg_req && msg_type == 2'b10) |=> !(msg_req && msg_type == 2'b10));

    // R7
    ptrace_off_halted_chk: assert property (@(posedge clk) disable iff (port_rst)
        ($past(core_status) == DBG_CODE && !$past(port_rst)) |-> !ptrace_gate);

    // R10
    drop_unconfigured_chk: assert property (@(posedge clk) disable iff (port_rst)
        msg_accept |-> (msg_in_valid && rw_gate));

    // R11
    typed_request_chk: assert property (@(posedge clk) disable iff (port_rst)
        msg_req |-> (msg_type != 2'b00));

endmodule

bind dbg_access_ctrl dbg_access_chk #(.STAT_W(STAT_W), .DBG_CODE(DBG_CODE)) u_chk (.*);

// File: tb/sim_dbg_access_ctrl.sv
module sim_dbg_access_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       port_rst, sys_rst;
    logic       cfg_access, cfg_dbg_en, cfg_halt_rst;
    logic [1:0] core_status;
    logic       ptrace_en, dtrace_en, msg_in_valid;
    logic       halt_req, ptrace_gate, dtrace_gate, rw_gate, msg_accept, msg_req;
    logic [1:0] msg_type;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbg_access_ctrl u0 (
        .clk(clk), .port_rst(port_rst), .sys_rst(sys_rst),
        .cfg_access(cfg_access), .cfg_dbg_en(cfg_dbg_en), .cfg_halt_rst(cfg_halt_rst),
        .core_status(core_status), .ptrace_en(ptrace_en), .dtrace_en(dtrace_en),
        .msg_in_valid(msg_in_valid), .halt_req(halt_req), .ptrace_gate(ptrace_gate),
        .dtrace_gate(dtrace_gate), .rw_gate(rw_gate), .msg_accept(msg_accept),
        .msg_req(msg_req), .msg_type(msg_type)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Message seen as a code: 0 when no request, else the type.
    function automatic int msg_code();
        return msg_req ? int'(msg_type) : 0;
    endfunction

    task automatic set_cfg(input logic a, input logic d, input logic h);
        cfg_access = a; cfg_dbg_en = d; cfg_halt_rst = h;
    endtask

    initial begin
        port_rst = 1'b1; sys_rst = 1'b1;
        set_cfg(1'b0, 1'b0, 1'b0);
        core_status = 2'b00; ptrace_en = 1'b0; dtrace_en = 1'b0; msg_in_valid = 1'b0;
        #1;
        step(); step(); step();
        chk("R1 msg in reset", int'(msg_req), 0);
        chk("R1 halt in reset", int'(halt_req), 0);
        chk("R1 cfg cleared", int'(rw_gate), 0);

        // Configuration sweep while system reset holds messages back.
        port_rst = 1'b0;
        for (int c = 0; c < 8; c++) begin
            set_cfg(c[2], c[1], c[0]);
            step();
            chk("R4 halt per cfg", int'(halt_req), int'(c[1] & c[0]));
            chk("R8 rw_gate per cfg", int'(rw_gate), int'(c[2]));
            chk("R2 held in sys reset", int'(msg_req), 0);
            for (int v = 0; v < 2; v++) begin
                msg_in_valid = v[0];
                #1;
                chk("R10 accept", int'(msg_accept), v & int'(c[2]));
            end
            msg_in_valid = 1'b0;
        end

        // Queue status and resync behind the identification request.
        set_cfg(1'b1, 1'b1, 1'b1);
        ptrace_en = 1'b1;
        step();
        core_status = 2'b11; step(); step();
        core_status = 2'b00; step(); step();
        chk("R2 still held", int'(msg_req), 0);
        sys_rst = 1'b0;
        set_cfg(1'b0, 1'b0, 1'b0);
        #1;
        chk("R11 first is ID", msg_code(), 1);
        step();
        chk("R11 second is status", msg_code(), 2);
        step();
        chk("R11 third is resync", msg_code(), 3);
        step();
        chk("R11 queue empty", msg_code(), 0);
        msg_in_valid = 1'b1; #1;
        chk("R3 access kept", int'(msg_accept), 1);
        chk("R3 rw kept", int'(rw_gate), 1);
        chk("R3 halt kept", int'(halt_req), 1);
        msg_in_valid = 1'b0;

        // Halt release and single status.
        core_status = 2'b11;
        step();
        chk("R4 halt before release", int'(halt_req), 1);
        chk("R7 ptrace off halted", int'(ptrace_gate), 0);
        chk("R5 not yet", msg_code(), 0);
        step();
        chk("R4 halt released", int'(halt_req), 0);
        chk("R5 status once", msg_code(), 2);
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R6 no repeat", msg_code(), 0);
        end
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 2; p++) begin
                dtrace_en = d[0]; ptrace_en = p[0]; #1;
                chk("R8 dtrace in debug", int'(dtrace_gate), d);
                chk("R7 ptrace in debug", int'(ptrace_gate), 0);
                chk("R8 rw in debug", int'(rw_gate), 1);
            end
        end

        // Exit with program trace off: no resync.
        ptrace_en = 1'b0; core_status = 2'b00;
        step(); step();
        chk("R9 no resync", msg_code(), 0);
        step();
        chk("R9 still none", msg_code(), 0);
        ptrace_en = 1'b1; #1;
        chk("R7 ptrace running", int'(ptrace_gate), 1);

        // Non-halt codes and entry from each code.
        for (int s = 0; s < 3; s++) begin
            core_status = s[1:0]; step(); step();
            chk("R5 other codes silent", msg_code(), 0);
            core_status = 2'b11; step(); step();
            chk("R12 status from any code", msg_code(), 2);
            core_status = 2'b00; step(); step();
            chk("R9 resync on exit", msg_code(), 3);
            step();
        end

        // Status code x trace-enable sweep on the gate.
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                core_status = s[1:0]; ptrace_en = p[0];
                step(); step();
                chk("R7 ptrace sweep", int'(ptrace_gate), p & int'(s != 3));
            end
        end
        core_status = 2'b00; ptrace_en = 1'b0;
        step(); step(); step(); step();

        // Running-access mode: halt-at-reset ignored, no status.
        port_rst = 1'b1; sys_rst = 1'b1;
        step();
        chk("R1 reset clears cfg", int'(rw_gate), 0);
        chk("R1 quiet", int'(msg_req), 0);
        port_rst = 1'b0;
        set_cfg(1'b1, 1'b0, 1'b1);
        step();
        chk("R4 halt ignored", int'(halt_req), 0);
        sys_rst = 1'b0; #1;
        chk("R2 ID after reset", msg_code(), 1);
        step();
        chk("R2 ID single", msg_code(), 0);
        ptrace_en = 1'b1; core_status = 2'b11;
        step(); step();
        chk("R5 no status without enable", msg_code(), 0);
        core_status = 2'b00; step(); step();
        chk("R9 resync running mode", msg_code(), 3);
        step();

        // Unconfigured access drops data messages.
        port_rst = 1'b1; sys_rst = 1'b1; set_cfg(1'b0, 1'b0, 1'b0);
        step();
        port_rst = 1'b0; step();
        sys_rst = 1'b0;
        msg_in_valid = 1'b1; #1;
        chk("R10 dropped", int'(msg_accept), 0);
        msg_in_valid = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule